// File: doc/BRIEF.md
# Interrupt Coalescing Counter and Delay Timer

This block reduces the interrupt rate of one DMA channel. It counts descriptor completions down from a programmable threshold and raises a completion-flag set pulse once every N completions. Every completion also restarts a one-shot delay timer. If that timer runs out before the threshold is reached, a delay-flag set pulse is raised, so that a trickle of completions below the threshold is still reported in bounded time.

The threshold and delay come from two 8-bit fields of the channel's control register. The start path of the channel gives a reload strobe. A prescaler outside the block gives the timer tick. The two set pulses go to the status register bank, which also holds the clear and mask logic. The live counter and timer values go to the register readback path.

Top module: `irq_coalescer`

## Requirements
- R1: After reset both set pulses are low, `cntLive` reads 1 and `timerLive` reads 0.
- R2: A completion pulse loads the timer with `delayVal` (control bits 31:24) and restarts it as a one-shot. `timerLive` shows the new value on the cycle after the pulse.
- R3: A completion pulse decrements the counter. When the counter would reach zero, `cmplFlagSet` goes high for one cycle on the cycle after the pulse, and the counter reloads from `thresholdVal` (control bits 23:16).
- R4: While the timer is running, each tick lowers it by one. The tick that brings it to zero raises `delayFlagSet` for one cycle and reloads the counter from `thresholdVal`. After that the timer stays stopped. A completion in the same cycle as that tick takes precedence: the timer restarts and no delay flag is raised.
- R5: `reloadStrobe` loads the counter from `thresholdVal` on the next cycle. A completion that arrives in the same cycle is not counted and raises no completion flag.
- R6: Without a tick or a completion, the timer value holds. Without a completion, a reload or an expiry, the counter value holds.
- R7: A completion with `delayVal` equal to 0 leaves the timer at 0 and stopped, and no delay flag follows.
- R8: A threshold of 0 acts as 256: after a reload with threshold 0, the 256th completion raises the completion flag and none before it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmplPulse | input | 1 | One-cycle pulse per finished descriptor |
| reloadStrobe | input | 1 | Channel start; reloads the counter |
| tick | input | 1 | Timer count enable from the prescaler |
| thresholdVal | input | 8 | Completion threshold field |
| delayVal | input | 8 | Delay timer load value |
| cmplFlagSet | output | 1 | Set pulse for the completion status flag |
| delayFlagSet | output | 1 | Set pulse for the delay status flag |
| cntLive | output | 8 | Current completion counter value |
| timerLive | output | 8 | Current delay timer value |

## Verification
Each result is registered once. The counter, the timer and both set pulses therefore show the effect of an input on the clock edge that samples it, and are visible one cycle after the input. The bench drives each input at a falling edge, so it is sampled at the next rising edge. It reads the outputs at the falling edge that follows, and a behavioural model, updated on the same rising edge, is compared with the design at every falling edge. Directed checks after each stimulus also read the outputs at that falling edge. This covers the collision cases: completion together with expiry, and completion together with reload.

// File: rtl/irq_coalescer_pkg.sv
package irq_coalescer_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadTmr;
    logic decTmr;
    logic loadCnt;
    logic decCnt;
  } coalStrobes_t;
endpackage

// File: rtl/irq_coal_ctrl.sv
module irq_coal_ctrl
  import irq_coalescer_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmplPulse,
  input  logic         reloadStrobe,
  input  logic         tick,
  input  logic         delayZero,
  input  logic         cntAtOne,
  input  logic         timerAtOne,
  output coalStrobes_t strobes,
  output logic         cmplFlagSet,
  output logic         delayFlagSet
);
  logic timerRun;
  logic expireNow;
  logic iocHit;

  always_comb begin
    strobes.loadTmr = cmplPulse;
    strobes.decTmr  = timerRun && tick && !cmplPulse;
    expireNow       = strobes.decTmr && timerAtOne;
    iocHit          = cmplPulse && !reloadStrobe && cntAtOne;
    strobes.loadCnt = reloadStrobe || expireNow || iocHit;
    strobes.decCnt  = cmplPulse && !reloadStrobe && !cntAtOne;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerRun     <= 1'b0;
      cmplFlagSet  <= 1'b0;
      delayFlagSet <= 1'b0;
    end else begin
      if (cmplPulse)      timerRun <= !delayZero;
      else if (expireNow) timerRun <= 1'b0;
      cmplFlagSet  <= iocHit;
      delayFlagSet <= expireNow;
    end
  end
endmodule

// File: rtl/irq_coal_datapath.sv
module irq_coal_datapath
  import irq_coalescer_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TMR_W     = 8,
  parameter int RST_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  coalStrobes_t     strobes,
  input  logic [CNT_W-1:0] thresholdVal,
  input  logic [TMR_W-1:0] delayVal,
  output logic [CNT_W-1:0] cntVal,
  output logic [TMR_W-1:0] timerVal,
  output logic             cntAtOne,
  output logic             timerAtOne
);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [TMR_W-1:0] TMR_ONE   = TMR_W'(1);
  localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(RST_COUNT);

  assign cntAtOne   = (cntVal == CNT_ONE);
  assign timerAtOne = (timerVal == TMR_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntVal   <= CNT_RESET;
      timerVal <= '0;
    end else begin
      if (strobes.loadCnt)     cntVal <= thresholdVal;
      else if (strobes.decCnt) cntVal <= cntVal - CNT_ONE;
      if (strobes.loadTmr)     timerVal <= delayVal;
      else if (strobes.decTmr) timerVal <= timerVal - TMR_ONE;
    end
  end
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
  import irq_coalescer_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TMR_W     = 8,
  parameter int RST_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmplPulse,
  input  logic             reloadStrobe,
  input  logic             tick,
  input  logic [CNT_W-1:0] thresholdVal,
  input  logic [TMR_W-1:0] delayVal,
  output logic             cmplFlagSet,
  output logic             delayFlagSet,
  output logic [CNT_W-1:0] cntLive,
  output logic [TMR_W-1:0] timerLive
);
  coalStrobes_t strobes;
  logic cntAtOne;
  logic timerAtOne;
  logic delayZero;

  assign delayZero = (delayVal == '0);

  irq_coal_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmplPulse    (cmplPulse),
    .reloadStrobe (reloadStrobe),
    .tick         (tick),
    .delayZero    (delayZero),
    .cntAtOne     (cntAtOne),
    .timerAtOne   (timerAtOne),
    .strobes      (strobes),
    .cmplFlagSet  (cmplFlagSet),
    .delayFlagSet (delayFlagSet)
  );

  irq_coal_datapath #(
    .CNT_W     (CNT_W),
    .TMR_W     (TMR_W),
    .RST_COUNT (RST_COUNT)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .thresholdVal (thresholdVal),
    .delayVal     (delayVal),
    .cntVal       (cntLive),
    .timerVal     (timerLive),
    .cntAtOne     (cntAtOne),
    .timerAtOne   (timerAtOne)
  );
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmplPulse,
  input logic             reloadStrobe,
  input logic             tick,
  input logic [CNT_W-1:0] thresholdVal,
  input logic [TMR_W-1:0] delayVal,
  input logic             cmplFlagSet,
  input logic             delayFlagSet,
  input logic [CNT_W-1:0] cntLive,
  input logic [TMR_W-1:0] timerLive
);
  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmplPulse |=> timerLive == $past(delayVal)); // R2

  AST_IOC_FROM_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
    cmplPulse && !reloadStrobe && cntLive == CNT_W'(1)
      |=> cmplFlagSet && cntLive == $past(thresholdVal)); // R3

  AST_DLY_ON_LAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delayFlagSet) |-> $past(tick) && !$past(cmplPulse)
      && $past(timerLive) == TMR_W'(1)); // R4

  AST_RELOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    reloadStrobe |=> cntLive == $past(thresholdVal) && !cmplFlagSet); // R5

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cmplPulse |=> $stable(timerLive)); // R6

  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    timerLive == '0 |=> !delayFlagSet); // R7

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmplFlagSet && delayFlagSet)); // R4
endmodule

bind irq_coalescer irq_coalescer_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmplPulse    (cmplPulse),
  .reloadStrobe (reloadStrobe),
  .tick         (tick),
  .thresholdVal (thresholdVal),
  .delayVal     (delayVal),
  .cmplFlagSet  (cmplFlagSet),
  .delayFlagSet (delayFlagSet),
  .cntLive      (cntLive),
  .timerLive    (timerLive)
);

// File: tb/irq_coalescer_bench.sv
`timescale 1ns/1ps
module irq_coalescer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmplPulse = 1'b0;
  logic       reloadStrobe = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] thresholdVal = 8'd0;
  logic [7:0] delayVal = 8'd0;
  logic       cmplFlagSet, delayFlagSet;
  logic [7:0] cntLive, timerLive;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model state
  int mCnt = 1, mTmr = 0;
  bit mRun = 0, mIoc = 0, mDly = 0;

  always #2 clk = ~clk;

  irq_coalescer u_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .cmplPulse(cmplPulse), .reloadStrobe(reloadStrobe),
    .tick(tick), .thresholdVal(thresholdVal), .delayVal(delayVal),
    .cmplFlagSet(cmplFlagSet), .delayFlagSet(delayFlagSet),
    .cntLive(cntLive), .timerLive(timerLive)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = 1; mTmr = 0; mRun = 0; mIoc = 0; mDly = 0;
    end else begin
      bit expire;
      expire = 0; mIoc = 0; mDly = 0;
      if (cmplPulse) begin
        mTmr = delayVal; mRun = (delayVal != 0);
      end else if (mRun && tick) begin
        mTmr = mTmr - 1;
        if (mTmr == 0) begin mRun = 0; expire = 1; end
      end
      if (reloadStrobe) mCnt = thresholdVal;
      else if (cmplPulse) begin
        mCnt = (mCnt + 255) % 256;
        if (mCnt == 0) begin mIoc = 1; mCnt = thresholdVal; end
      end
      if (expire) begin mCnt = thresholdVal; mDly = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (cmplFlagSet !== mIoc || cntLive !== 8'(mCnt)) begin
        mismatched++;
        $display("FAIL R3 model: ioc=%0d cnt=%0d expected ioc=%0d cnt=%0d",
                 cmplFlagSet, cntLive, mIoc, mCnt);
      end
      if (delayFlagSet !== mDly || timerLive !== 8'(mTmr)) begin
        mismatched++;
        $display("FAIL R4 model: dly=%0d tmr=%0d expected dly=%0d tmr=%0d",
                 delayFlagSet, timerLive, mDly, mTmr);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs held for one rising edge; returns at the following falling edge
  task automatic drive(input bit c, input bit r, input bit t);
    cmplPulse = c; reloadStrobe = r; tick = t;
    @(negedge clk);
    cmplPulse = 0; reloadStrobe = 0; tick = 0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int flagCount, firstFlag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cntLive == 8'd1, "R1 cnt", cntLive, 1);
    check(timerLive == 8'd0, "R1 tmr", timerLive, 0);
    check(!cmplFlagSet && !delayFlagSet, "R1 flags", cmplFlagSet + delayFlagSet, 0);

    thresholdVal = 8'd3; delayVal = 8'd4;
    drive(0, 1, 0);
    check(cntLive == 8'd3, "R5 reload", cntLive, 3);
    drive(1, 0, 0);
    check(timerLive == 8'd4, "R2 load", timerLive, 4);
    check(cntLive == 8'd2, "R3 dec", cntLive, 2);
    repeat (3) drive(0, 0, 0);
    check(timerLive == 8'd4, "R6 hold tmr", timerLive, 4);
    check(cntLive == 8'd2, "R6 hold cnt", cntLive, 2);
    drive(1, 0, 0);
    drive(1, 0, 0);
    check(cmplFlagSet == 1'b1, "R3 flag", cmplFlagSet, 1);
    check(cntLive == 8'd3, "R3 reload", cntLive, 3);
    drive(0, 0, 0);
    check(cmplFlagSet == 1'b0, "R3 single pulse", cmplFlagSet, 0);

    // expiry
    drive(1, 0, 0);
    repeat (3) drive(0, 0, 1);
    check(timerLive == 8'd1 && !delayFlagSet, "R4 count down", timerLive, 1);
    drive(0, 0, 1);
    check(delayFlagSet == 1'b1, "R4 flag", delayFlagSet, 1);
    check(cntLive == 8'd3, "R4 cnt reload", cntLive, 3);
    drive(0, 0, 1);
    check(delayFlagSet == 1'b0 && timerLive == 8'd0, "R4 one-shot", delayFlagSet, 0);

    // completion collides with the last tick
    drive(1, 0, 0);
    repeat (3) drive(0, 0, 1);
    drive(1, 0, 1);
    check(delayFlagSet == 1'b0, "R4 collision flag", delayFlagSet, 0);
    check(timerLive == 8'd4, "R4 collision restart", timerLive, 4);
    check(cntLive == 8'd1, "R3 collision count", cntLive, 1);

    // reload wins over completion
    drive(1, 1, 0);
    check(cntLive == 8'd3 && !cmplFlagSet, "R5 reload vs cmpl", cntLive, 3);

    // zero delay
    delayVal = 8'd0;
    drive(1, 0, 0);
    check(timerLive == 8'd0, "R7 tmr zero", timerLive, 0);
    flagCount = 0;
    for (int i = 0; i < 10; i++) begin
      drive(0, 0, 1);
      flagCount += delayFlagSet;
    end
    check(flagCount == 0, "R7 no delay flag", flagCount, 0);

    // threshold zero acts as 256
    thresholdVal = 8'd0;
    drive(0, 1, 0);
    flagCount = 0; firstFlag = 0;
    for (int i = 1; i <= 256; i++) begin
      drive(1, 0, 0);
      if (cmplFlagSet) begin
        flagCount++;
        if (firstFlag == 0) firstFlag = i;
      end
    end
    check(flagCount == 1 && firstFlag == 256, "R8 wrap", firstFlag, 256);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        thresholdVal = 8'($urandom_range(0, 6));
        delayVal = 8'($urandom_range(0, 5));
      end
      drive($urandom_range(0, 5) == 0, $urandom_range(0, 40) == 0,
            $urandom_range(0, 1) == 1);
    end
    finish_run();
  end
endmodule